// File: doc/BRIEF.md
# Load/Store Byte-Lane and Extension Unit

This unit sits between a processor core and a data memory organised as 32-bit words. For every access the core presents a base register value, a 16-bit signed offset and an access kind. The unit adds the base to the sign-extended offset, sends the word address to memory, and decides from the two low address bits which byte lanes take part. Byte order is little-endian: address bits 1..0 name the byte lane, and bit 1 names the half-word lane.

For stores the unit copies the low part of the register into every lane of the write word, so the memory only has to honour the per-byte write enables. For loads the memory answers one cycle after the request. The unit keeps the kind and the lane of the pending load, picks the lane out of the returned word, and sign- or zero-extends it to 32 bits. A word access that is not word-aligned, or a half-word access at an odd address, raises a misalignment flag in the request cycle and sends nothing to memory.

Top module: `lsu_lane_unit`

## Requirements
- R1: While a request is presented, mem_addr_o equals bits 31..2 of base_i plus the 16-bit offset_i sign-extended to 32 bits, with modulo-2^32 wrap.
- R2: A word access whose address bits 1..0 are not 00, or a half-word access with address bit 0 set, drives misalign_o high in the request cycle with mem_req_o, mem_we_o and every bit of mem_be_o low, and produces no load_valid_o in the next cycle.
- R3: An aligned store (op_i 4'b1010 word, 4'b1001 half, 4'b1000 byte) drives mem_req_o and mem_we_o high, with mem_be_o 4'b1111 for a word, 4'b0011 or 4'b1100 for a half word when address bit 1 is 0 or 1, and 4'b0001 shifted left by address bits 1..0 for a byte.
- R4: mem_wdata_o carries store_data_i unchanged for a word store, store_data_i[15:0] in both half-word lanes for a half store, and store_data_i[7:0] in all four byte lanes for a byte store.
- R5: An aligned load (op_i 4'b0010 word, 4'b0001 signed half, 4'b0101 unsigned half, 4'b0000 signed byte, 4'b0100 unsigned byte) drives mem_req_o high with mem_we_o low and mem_be_o 4'b0000.
- R6: load_valid_o is high in exactly the cycle after each accepted load request and low otherwise; load_data_o is zero while load_valid_o is low.
- R7: A word load returns mem_rdata_i unchanged on load_data_o.
- R8: A signed half or byte load returns the addressed lane of mem_rdata_i sign-extended to 32 bits.
- R9: An unsigned half or byte load returns the addressed lane of mem_rdata_i zero-extended to 32 bits.
- R10: With req_valid_i low, or with an op_i code outside the eight listed in R3 and R5, mem_req_o, mem_we_o, misalign_o and mem_be_o stay low and no load_valid_o follows.
- R11: While rst_ni is low, load_valid_o is low and load_data_o is zero, even with a load outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request from the core |
| op_i | input | 4 | Access kind: bit 3 store, bit 2 unsigned, bits 1..0 size (00 byte, 01 half, 10 word) |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed address offset |
| store_data_i | input | 32 | Register value to store |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 30 | Word address to memory |
| mem_be_o | output | 4 | Per-byte write enables |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Read word, valid one cycle after a load request |
| misalign_o | output | 1 | Misaligned access in the request cycle |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |

## Verification
The load return path and the request path run in the same cycle: a load result is finished from the registered lane and kind while a new access, possibly a store or a misaligned access, is being decoded. The bench provokes this by issuing a byte load and, in the very next cycle, a byte store to another lane while the memory word for the load is being returned. It then judges the extended load result and the store enables, data and address in that one cycle, and does the same with two loads back to back whose lanes and extensions differ, so a pending state that leaks into the new request, or the reverse, shows up at once.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic      store;
    logic      uns;
    acc_size_e size;
  } acc_op_t;

  // Unsigned stores and the reserved size are not access kinds.
  function automatic logic op_legal(acc_op_t op);
    return (op.size != SZ_RSVD) && !(op.store && op.uns) &&
           !(op.uns && op.size == SZ_WORD);
  endfunction

endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned OW = 16
) (
  input  logic [DW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  acc_size_e     size_i,
  output logic [DW-1:0] ea_o,
  output logic          misalign_o
);

  localparam int unsigned NB = DW / 8;
  localparam int unsigned LW = $clog2(NB);

  logic [DW-1:0] off_sext;

  assign off_sext = {{(DW-OW){offset_i[OW-1]}}, offset_i};
  assign ea_o     = base_i + off_sext;

  always_comb begin
    unique case (size_i)
      SZ_WORD: misalign_o = |ea_o[LW-1:0];
      SZ_HALF: misalign_o = ea_o[0];
      default: misalign_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned NB = DW / 8,
  localparam int unsigned LW = $clog2(NB)
) (
  input  logic          en_i,
  input  acc_size_e     size_i,
  input  logic [LW-1:0] lane_i,
  input  logic [DW-1:0] data_i,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] wdata_o
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam logic [LW-1:0] LANE = LW'(b);

    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin
          wdata_o[8*b +: 8] = data_i[7:0];
          be_o[b]           = en_i && (lane_i == LANE);
        end
        SZ_HALF: begin
          wdata_o[8*b +: 8] = data_i[8*(b%2) +: 8];
          be_o[b]           = en_i && (lane_i[LW-1:1] == LANE[LW-1:1]);
        end
        SZ_WORD: begin
          wdata_o[8*b +: 8] = data_i[8*b +: 8];
          be_o[b]           = en_i;
        end
        default: begin
          wdata_o[8*b +: 8] = '0;
          be_o[b]           = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned NB = DW / 8,
  localparam int unsigned LW = $clog2(NB)
) (
  input  logic [DW-1:0] rdata_i,
  input  logic [LW-1:0] lane_i,
  input  acc_size_e     size_i,
  input  logic          uns_i,
  output logic [DW-1:0] data_o
);

  logic [DW-1:0] shifted;
  logic          fill;

  assign shifted = rdata_i >> {lane_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        fill   = !uns_i && shifted[7];
        data_o = {{(DW-8){fill}}, shifted[7:0]};
      end
      SZ_HALF: begin
        fill   = !uns_i && shifted[15];
        data_o = {{(DW-16){fill}}, shifted[15:0]};
      end
      default: begin
        fill   = 1'b0;
        data_o = rdata_i;
      end
    endcase
  end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned OW = 16,
  localparam int unsigned NB  = DW / 8,
  localparam int unsigned LW  = $clog2(NB),
  localparam int unsigned MAW = DW - LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [3:0]     op_i,
  input  logic [DW-1:0]  base_i,
  input  logic [OW-1:0]  offset_i,
  input  logic [DW-1:0]  store_data_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic [NB-1:0]  mem_be_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           misalign_o,
  output logic           load_valid_o,
  output logic [DW-1:0]  load_data_o
);

  acc_op_t       op;
  logic          legal;
  logic          mis_raw;
  logic          go;
  logic [DW-1:0] ea;

  assign op    = acc_op_t'(op_i);
  assign legal = req_valid_i && op_legal(op);

  lsu_ea_gen #(.DW(DW), .OW(OW)) u_ea (
    .base_i    (base_i),
    .offset_i  (offset_i),
    .size_i    (op.size),
    .ea_o      (ea),
    .misalign_o(mis_raw)
  );

  assign go         = legal && !mis_raw;
  assign misalign_o = legal && mis_raw;
  assign mem_req_o  = go;
  assign mem_we_o   = go && op.store;
  assign mem_addr_o = ea[DW-1:LW];

  lsu_store_lane #(.DW(DW)) u_st (
    .en_i   (mem_we_o),
    .size_i (op.size),
    .lane_i (ea[LW-1:0]),
    .data_i (store_data_i),
    .be_o   (mem_be_o),
    .wdata_o(mem_wdata_o)
  );

  // Pending load: kind and lane held for the cycle the memory answers.
  logic          ld_pend_q;
  acc_size_e     ld_size_q;
  logic          ld_uns_q;
  logic [LW-1:0] ld_lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q <= 1'b0;
      ld_size_q <= SZ_WORD;
      ld_uns_q  <= 1'b0;
      ld_lane_q <= '0;
    end else begin
      ld_pend_q <= go && !op.store;
      if (go && !op.store) begin
        ld_size_q <= op.size;
        ld_uns_q  <= op.uns;
        ld_lane_q <= ea[LW-1:0];
      end
    end
  end

  logic [DW-1:0] ext_data;

  lsu_load_ext #(.DW(DW)) u_ld (
    .rdata_i(mem_rdata_i),
    .lane_i (ld_lane_q),
    .size_i (ld_size_q),
    .uns_i  (ld_uns_q),
    .data_o (ext_data)
  );

  assign load_valid_o = ld_pend_q;
  assign load_data_o  = ld_pend_q ? ext_data : '0;

  AST_MIS_BLOCKS_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!mem_req_o && !mem_we_o && mem_be_o == '0)); // R2
  AST_MIS_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !load_valid_o); // R2
  AST_STORE_BE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) == 1 || mem_be_o == 4'b0011 ||
                  mem_be_o == 4'b1100 || mem_be_o == 4'b1111)); // R3
  AST_STORE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_be_o != '0) |-> (mem_we_o && mem_req_o)); // R3
  AST_LOAD_NO_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_be_o == '0)); // R5
  AST_LOAD_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> load_valid_o); // R6
  AST_RESULT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |-> $past(mem_req_o && !mem_we_o)); // R6
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_valid_o |-> (load_data_o == '0)); // R6
  AST_UNS_BYTE_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_o && ld_uns_q && ld_size_q == SZ_BYTE) |-> (load_data_o[DW-1:8] == '0)); // R9
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!mem_req_o && !misalign_o)); // R10

endmodule

// File: tb/sim_lsu_lane_unit.sv
`timescale 1ns/1ps
module sim_lsu_lane_unit;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i;
  logic [3:0]  op_i;
  logic [31:0] base_i;
  logic [15:0] offset_i;
  logic [31:0] store_data_i;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i;
  logic        misalign_o;
  logic        load_valid_o;
  logic [31:0] load_data_o;

  always #5 clk_i = ~clk_i;

  lsu_lane_unit u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [3:0] OP_LB = 4'b0000, OP_LH = 4'b0001, OP_LW = 4'b0010,
                         OP_LBU = 4'b0100, OP_LHU = 4'b0101,
                         OP_SB = 4'b1000, OP_SH = 4'b1001, OP_SW = 4'b1010;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] sdata;
    logic [31:0] rdata;
    logic [29:0] addr;
    logic [3:0]  be;
    logic        mis;
    logic [31:0] res;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{OP_LW,  32'h0000_1000, 16'h0004, 32'h0, 32'hDEAD_BEEF, 30'h401, 4'h0, 1'b0, 32'hDEAD_BEEF},
    '{OP_LW,  32'h0000_2000, 16'hFFFC, 32'h0, 32'h1234_5678, 30'h7FF, 4'h0, 1'b0, 32'h1234_5678},
    '{OP_LW,  32'h0000_1000, 16'h0002, 32'h0, 32'h0,         30'h400, 4'h0, 1'b1, 32'h0},
    '{OP_LH,  32'h0000_0100, 16'h0002, 32'h0, 32'h8001_7FFF, 30'h040, 4'h0, 1'b0, 32'hFFFF_8001},
    '{OP_LHU, 32'h0000_0100, 16'h0002, 32'h0, 32'h8001_7FFF, 30'h040, 4'h0, 1'b0, 32'h0000_8001},
    '{OP_LH,  32'h0000_0100, 16'h0000, 32'h0, 32'h0000_1234, 30'h040, 4'h0, 1'b0, 32'h0000_1234},
    '{OP_LH,  32'h0000_0100, 16'h0001, 32'h0, 32'h0,         30'h040, 4'h0, 1'b1, 32'h0},
    '{OP_LB,  32'h0000_0200, 16'h0003, 32'h0, 32'h80FF_7F01, 30'h080, 4'h0, 1'b0, 32'hFFFF_FF80},
    '{OP_LBU, 32'h0000_0200, 16'h0003, 32'h0, 32'h80FF_7F01, 30'h080, 4'h0, 1'b0, 32'h0000_0080},
    '{OP_LB,  32'h0000_0200, 16'h0001, 32'h0, 32'h80FF_7F01, 30'h080, 4'h0, 1'b0, 32'h0000_007F},
    '{OP_LBU, 32'h0000_0200, 16'h0002, 32'h0, 32'h80FF_7F01, 30'h080, 4'h0, 1'b0, 32'h0000_00FF},
    '{OP_SW,  32'h0000_3000, 16'h0008, 32'hCAFE_F00D, 32'h0, 30'hC02, 4'hF, 1'b0, 32'hCAFE_F00D},
    '{OP_SW,  32'h0000_3000, 16'h0001, 32'hCAFE_F00D, 32'h0, 30'hC00, 4'h0, 1'b1, 32'h0},
    '{OP_SH,  32'h0000_3000, 16'h0002, 32'h1234_ABCD, 32'h0, 30'hC00, 4'hC, 1'b0, 32'hABCD_ABCD},
    '{OP_SH,  32'h0000_3000, 16'h0000, 32'h1234_ABCD, 32'h0, 30'hC00, 4'h3, 1'b0, 32'hABCD_ABCD},
    '{OP_SH,  32'h0000_3000, 16'h0003, 32'h1234_ABCD, 32'h0, 30'hC00, 4'h0, 1'b1, 32'h0},
    '{OP_SB,  32'h0000_3000, 16'h0001, 32'h1122_3344, 32'h0, 30'hC00, 4'h2, 1'b0, 32'h4444_4444},
    '{OP_SB,  32'h0000_3000, 16'h0003, 32'h1122_3344, 32'h0, 30'hC00, 4'h8, 1'b0, 32'h4444_4444},
    '{OP_SB,  32'h0000_0010, 16'hFFF0, 32'h0000_00A5, 32'h0, 30'h000, 4'h1, 1'b0, 32'hA5A5_A5A5},
    '{OP_LB,  32'h0000_0000, 16'hFFFF, 32'h0, 32'h7F00_0000, 30'h3FFF_FFFF, 4'h0, 1'b0, 32'h0000_007F}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] op, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] sd);
    req_valid_i = v; op_i = op; base_i = b; offset_i = o; store_data_i = sd;
  endtask

  function automatic string ld_req(input logic [3:0] op);
    if (op[1:0] == 2'b10) return "R7";
    return op[2] ? "R9" : "R8";
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    drive(1'b0, 4'h0, 32'h0, 16'h0, 32'h0);
    mem_rdata_i = 32'h0;
    repeat (2) @(negedge clk_i);
    #1;
    chk("R11", "load_valid in reset", 32'(load_valid_o), 32'h0);
    chk("R11", "load_data in reset", load_data_o, 32'h0);
    chk("R10", "mem_req idle", 32'(mem_req_o), 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      @(negedge clk_i);
      drive(1'b1, v.op, v.base, v.off, v.sdata);
      #1;
      chk("R1", "mem_addr", 32'(mem_addr_o), 32'(v.addr));
      chk("R2", "misalign", 32'(misalign_o), 32'(v.mis));
      chk(v.mis ? "R2" : (v.op[3] ? "R3" : "R5"), "mem_req", 32'(mem_req_o), 32'(!v.mis));
      chk(v.op[3] ? "R3" : "R5", "mem_we", 32'(mem_we_o), 32'(v.op[3] && !v.mis));
      chk(v.mis ? "R2" : (v.op[3] ? "R3" : "R5"), "mem_be", 32'(mem_be_o), 32'(v.be));
      if (v.op[3] && !v.mis) chk("R4", "mem_wdata", mem_wdata_o, v.res);
      @(negedge clk_i);
      drive(1'b0, 4'h0, 32'h0, 16'h0, 32'h0);
      mem_rdata_i = v.rdata;
      #1;
      chk(v.mis ? "R2" : "R6", "load_valid", 32'(load_valid_o), 32'(!v.op[3] && !v.mis));
      if (!v.op[3] && !v.mis) chk(ld_req(v.op), "load_data", load_data_o, v.res);
      else chk("R6", "idle load_data", load_data_o, 32'h0);
    end

    // R10: request low with a misaligned word load pattern
    @(negedge clk_i);
    drive(1'b0, OP_LW, 32'h0000_1001, 16'h0, 32'h0);
    #1;
    chk("R10", "no req when idle", {mem_req_o, mem_we_o, misalign_o, mem_be_o}, 32'h0);
    // R10: reserved size and unsigned store codes
    @(negedge clk_i);
    drive(1'b1, 4'b0011, 32'h0000_1001, 16'h0, 32'h0);
    #1;
    chk("R10", "reserved size", {mem_req_o, mem_we_o, misalign_o, mem_be_o}, 32'h0);
    @(negedge clk_i);
    drive(1'b1, 4'b1100, 32'h0000_1000, 16'h0, 32'hFF);
    #1;
    chk("R10", "unsigned store code", {mem_req_o, mem_we_o, misalign_o, mem_be_o}, 32'h0);
    @(negedge clk_i);
    drive(1'b0, 4'h0, 32'h0, 16'h0, 32'h0);
    #1;
    chk("R10", "no result after illegal", 32'(load_valid_o), 32'h0);

    // Overlap: byte load, then a byte store while the load result returns
    @(negedge clk_i);
    drive(1'b1, OP_LB, 32'h0000_0400, 16'h0002, 32'h0);
    @(negedge clk_i);
    drive(1'b1, OP_SB, 32'h0000_0500, 16'h0001, 32'h0000_0066);
    mem_rdata_i = 32'h00C3_0000;
    #1;
    chk("R8", "overlap load data", load_data_o, 32'hFFFF_FFC3);
    chk("R6", "overlap load valid", 32'(load_valid_o), 32'h1);
    chk("R3", "overlap store be", 32'(mem_be_o), 32'h2);
    chk("R4", "overlap store data", mem_wdata_o, 32'h6666_6666);
    chk("R1", "overlap store addr", 32'(mem_addr_o), 32'h140);

    // Back-to-back loads with different lanes and extensions
    @(negedge clk_i);
    drive(1'b1, OP_LHU, 32'h0000_0600, 16'h0000, 32'h0);
    mem_rdata_i = 32'h0;
    #1;
    chk("R6", "no result after store", 32'(load_valid_o), 32'h0);
    @(negedge clk_i);
    drive(1'b1, OP_LH, 32'h0000_0600, 16'h0002, 32'h0);
    mem_rdata_i = 32'h1111_F00F;
    #1;
    chk("R9", "first of pair", load_data_o, 32'h0000_F00F);
    @(negedge clk_i);
    drive(1'b0, 4'h0, 32'h0, 16'h0, 32'h0);
    mem_rdata_i = 32'h9ABC_0000;
    #1;
    chk("R8", "second of pair", load_data_o, 32'hFFFF_9ABC);

    // R11: reset with a load outstanding
    @(negedge clk_i);
    drive(1'b1, OP_LW, 32'h0000_0700, 16'h0, 32'h0);
    @(negedge clk_i);
    drive(1'b0, 4'h0, 32'h0, 16'h0, 32'h0);
    mem_rdata_i = 32'h5555_AAAA;
    #1;
    chk("R7", "pending before reset", load_data_o, 32'h5555_AAAA);
    rst_ni = 1'b0;
    #1;
    chk("R11", "valid cleared by reset", 32'(load_valid_o), 32'h0);
    chk("R11", "data cleared by reset", load_data_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule